// File: doc/BRIEF.md
# Primary Clock Loss Detector with Fallback Select

This block guards a processor's primary system clock by measuring it against a slow, free-running reference oscillator. That reference is the same oscillator that feeds the watchdog. Everything in the block runs on the reference clock except a two-flop echo stage clocked by the primary clock. A request toggle is sent into the primary domain, and the primary clock sends it back. Each completed round trip proves the primary clock is alive and clears a reference-domain window counter. If the counter runs a whole window without a round trip, the primary clock has stopped or become too slow. The block then raises a sticky failure flag and a one-cycle exception pulse.

When a failure is detected while the primary source is selected, the block also raises a sticky override. This override steers an external glitch-free clock multiplexer onto the reference oscillator, so the processor can run its failure handler. No override is raised if the reference oscillator was already the selected source at the moment of detection.

Detection runs only while the enable input is high. A separate input reports that the reference oscillator's own monitor has failed. After that report, primary detection is shut off until reset. The window length is `WIN_CYC = REF_HZ * WIN_US / 1_000_000` reference cycles. A primary clock needs about two rising edges per window to count as alive, so it is flagged once its frequency falls below roughly `2e6 / WIN_US` Hz.

Top module: `clkloss_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, fail_flag, fail_exc and sel_override are all 0.
- R2: A primary clock whose period is at most (WIN_CYC-8)/2 reference cycles never raises fail_flag.
- R3: After the primary clock stops, with detection enabled and not disabled, fail_flag rises no later than WIN_CYC+6 reference cycles after the last primary rising edge. It rises no earlier than WIN_CYC-2P-6 cycles after that edge, where P is the primary period in reference cycles.
- R4: A primary clock whose period exceeds WIN_CYC+6 reference cycles is flagged as failed.
- R5: fail_exc is high for exactly one reference cycle per failure. That cycle is the first cycle in which fail_flag reads 1.
- R6: sel_override rises together with fail_flag when src_is_ref is 0 at detection. It never rises when src_is_ref is 1 at detection. sel_override is never 1 without fail_flag.
- R7: fail_flag and sel_override stay at 1 until reset, even if the primary clock resumes.
- R8: While mon_en is 0 no failure is declared and the window counter is held at zero. After mon_en returns to 1, a stopped primary is flagged between WIN_CYC-6 and WIN_CYC+6 cycles later.
- R9: A single cycle of refmon_fail at 1 disables primary detection until the next reset. After that reset, detection works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference (watchdog) oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_clk | input | 1 | Primary system clock being watched |
| mon_en | input | 1 | 1 = primary failure detection enabled |
| src_is_ref | input | 1 | 1 = reference oscillator is currently the selected system clock |
| refmon_fail | input | 1 | 1 = reference oscillator monitor has reported a failure |
| fail_flag | output | 1 | Sticky primary clock failure flag |
| fail_exc | output | 1 | One reference-cycle exception request on detection |
| sel_override | output | 1 | Sticky request to switch the system clock to the reference oscillator |

## Verification
The hardest case to reach from the ports is the edge of the window. This is a primary clock that is alive but slow, whose round trips finish just inside the window, next to one that has just stopped. The bench drives the primary clock from its own free-running process with a programmable half period, and can freeze it at any level. It records the reference cycle of every primary rising edge. A behavioural model then computes the time since the later of the last edge and the moment of enabling. Below the lower bound it demands a clear flag, and above the upper bound it demands a set flag. Between the two it accepts either value and follows the design once the flag is set.

// File: rtl/clkloss_pkg.sv
`timescale 1ns/1ps
package clkloss_pkg;

    // Reference-domain control state of the guard
    typedef struct packed {
        logic req;    // round-trip request toggle sent to the primary domain
        logic blind;  // reference monitor failed: detection off until reset
        logic fail;   // sticky failure flag
        logic ovr;    // sticky select override
        logic exc;    // one-cycle exception request
    } guard_st_t;

    function automatic int win_cycles(input int ref_hz, input int win_us);
        longint prod;
        prod = longint'(ref_hz) * longint'(win_us);
        return int'(prod / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/clkloss_sync2.sv
`timescale 1ns/1ps
module clkloss_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;

endmodule

// File: rtl/clkloss_timer.sv
`timescale 1ns/1ps
module clkloss_timer #(
    parameter int WIN_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,    // round trip seen this cycle
    input  logic hold,     // detection disabled or already failed
    output logic expired   // window fully elapsed without a round trip
);

    localparam int CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear || hold) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        expired = !clear && !hold && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_HOLD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !expired) else $error("hold did not restart window"); // R8

endmodule

// File: rtl/clkloss_guard.sv
`timescale 1ns/1ps
module clkloss_guard #(
    parameter int REF_HZ = 10_000,
    parameter int WIN_US = 2_000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic prim_clk,
    input  logic mon_en,
    input  logic src_is_ref,
    input  logic refmon_fail,
    output logic fail_flag,
    output logic fail_exc,
    output logic sel_override
);

    import clkloss_pkg::*;

    localparam int WIN_CYC = win_cycles(REF_HZ, WIN_US);

    guard_st_t st_d, st_q;
    logic      ack_prim;   // request echoed in the primary domain
    logic      ack_ref;    // echo brought back to the reference domain
    logic      alive;
    logic      hold;
    logic      expired;
    logic      fire;

    // Primary domain: two flops on prim_clk echo the request toggle
    clkloss_sync2 #(.WIDTH(1)) u_echo (
        .clk   (prim_clk),
        .rst_n (rst_n),
        .din   (st_q.req),
        .dout  (ack_prim)
    );

    // Reference domain: two flops bring the echo back
    clkloss_sync2 #(.WIDTH(1)) u_back (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .din   (ack_prim),
        .dout  (ack_ref)
    );

    clkloss_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .clear   (alive),
        .hold    (hold),
        .expired (expired)
    );

    always_comb begin
        alive = (ack_ref == st_q.req);
        hold  = !mon_en || st_q.blind || st_q.fail;
        fire  = expired && !refmon_fail;

        st_d       = st_q;
        st_d.req   = alive ? ~st_q.req : st_q.req;
        st_d.blind = st_q.blind | refmon_fail;
        st_d.fail  = st_q.fail | fire;
        st_d.ovr   = st_q.ovr | (fire & ~src_is_ref);
        st_d.exc   = fire;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fail_flag    = st_q.fail;
    assign fail_exc     = st_q.exc;
    assign sel_override = st_q.ovr;

    AST_EXC_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_exc |=> !fail_exc) else $error("exception longer than one cycle"); // R5
    AST_EXC_ON_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(fail_flag) |-> fail_exc) else $error("flag rose without exception"); // R5
    AST_FLAG_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_flag |=> fail_flag) else $error("failure flag dropped"); // R7
    AST_OVR_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sel_override |=> sel_override) else $error("override dropped"); // R7
    AST_OVR_NEEDS_FLAG: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sel_override |-> fail_flag) else $error("override without failure"); // R6
    AST_NO_OVR_ON_REF: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(sel_override) |-> !$past(src_is_ref)) else $error("override while on reference"); // R6
    AST_DISABLED_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!mon_en && !fail_flag) |=> !fail_flag) else $error("failure while disabled"); // R8
    AST_BLIND_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.blind && !fail_flag) |=> !fail_flag) else $error("failure after reference monitor loss"); // R9

endmodule

// File: tb/clkloss_guard_bench.sv
`timescale 1ns/1ps
module clkloss_guard_bench;

    localparam int REF_HZ = 50_000_000;
    localparam int WIN_US = 4;
    localparam int WIN    = 200;   // REF_HZ*WIN_US/1e6

    logic ref_clk = 1'b0;
    logic prim_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_en = 1'b0;
    logic src_is_ref = 1'b0;
    logic refmon_fail = 1'b0;
    logic fail_flag, fail_exc, sel_override;

    clkloss_guard #(.REF_HZ(REF_HZ), .WIN_US(WIN_US)) u_clkloss_guard (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .prim_clk     (prim_clk),
        .mon_en       (mon_en),
        .src_is_ref   (src_is_ref),
        .refmon_fail  (refmon_fail),
        .fail_flag    (fail_flag),
        .fail_exc     (fail_exc),
        .sel_override (sel_override)
    );

    always #10 ref_clk = ~ref_clk;   // 50 MHz reference

    int prim_half = 3;
    bit prim_run = 1'b1;
    always begin
        if (prim_run) begin
            #(prim_half) prim_clk = ~prim_clk;
        end else begin
            #5;
        end
    end

    int cyc = 0;
    int last_edge = 0;
    always @(posedge ref_clk) cyc <= cyc + 1;
    always @(posedge prim_clk) last_edge = cyc;

    int  n_vec = 0, n_bad = 0;
    bit  mon_on = 1'b0;
    bit  exp_fail = 1'b0, exp_ovr = 1'b0, blind_m = 1'b0, prev_flag = 1'b0;
    int  en_cyc = 0, cur_per = 1, exc_cnt = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, compared every reference cycle
    int  t0, gap, lo;
    bit  en_ok;
    always @(negedge ref_clk) begin
        if (rst_n && mon_on) begin
            t0    = (last_edge > en_cyc) ? last_edge : en_cyc;
            gap   = cyc - t0;
            lo    = WIN - 2 * cur_per - 6;
            en_ok = mon_en && !blind_m;
            if (!exp_fail) begin
                if (en_ok && gap > WIN + 6) begin
                    exp_fail = 1'b1;           // R3/R4 upper bound
                    exp_ovr  = !src_is_ref;
                end else if (en_ok && gap >= lo && fail_flag === 1'b1) begin
                    exp_fail = 1'b1;           // inside tolerance band
                    exp_ovr  = !src_is_ref;
                end
            end
            if (exp_fail || !en_ok || gap < lo || gap > WIN + 6)
                check("R2/R3/R7 fail_flag", fail_flag, exp_fail);
            check("R6 sel_override", sel_override, exp_ovr);
            check("R5 fail_exc", fail_exc, fail_flag && !prev_flag);
            if (fail_exc === 1'b1) exc_cnt++;
            prev_flag = fail_flag;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        rst_n  = 1'b0;
        wait_cyc(3);
        check("R1 reset fail_flag", fail_flag, 0);
        check("R1 reset fail_exc", fail_exc, 0);
        check("R1 reset sel_override", sel_override, 0);
        rst_n     = 1'b1;
        exp_fail  = 1'b0;
        exp_ovr   = 1'b0;
        blind_m   = 1'b0;
        prev_flag = 1'b0;
        exc_cnt   = 0;
        en_cyc    = cyc;
        mon_on    = 1'b1;
        wait_cyc(1);
        check("R1 after reset fail_flag", fail_flag, 0);
        check("R1 after reset sel_override", sel_override, 0);
    endtask

    task automatic set_en(input bit v);
        mon_en = v;
        if (v) en_cyc = cyc;
    endtask

    task automatic run_prim(input int half_ns, input int per_cyc);
        prim_half = half_ns;
        cur_per   = per_cyc;
        prim_run  = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: fast primary, never flagged
        run_prim(3, 1);
        set_en(1'b1);
        do_reset();
        wait_cyc(1000);
        check("R2 fast clock no flag", fail_flag, 0);

        // R2: slow but acceptable primary (40 reference cycles per period)
        run_prim(400, 40);
        do_reset();
        wait_cyc(2000);
        check("R2 slow clock no flag", fail_flag, 0);

        // R3, R5, R6, R7: stop a fast primary while it is selected
        run_prim(3, 1);
        src_is_ref = 1'b0;
        do_reset();
        wait_cyc(100);
        prim_run = 1'b0;
        wait_cyc(WIN + 10);
        check("R3 stopped clock flagged", fail_flag, 1);
        check("R6 override raised", sel_override, 1);
        check("R5 one exception", exc_cnt, 1);
        run_prim(3, 1);
        wait_cyc(500);
        check("R7 flag sticky after resume", fail_flag, 1);
        check("R7 override sticky after resume", sel_override, 1);
        check("R5 still one exception", exc_cnt, 1);

        // R6: reference already selected, no override
        src_is_ref = 1'b1;
        do_reset();
        wait_cyc(100);
        prim_run = 1'b0;
        wait_cyc(WIN + 10);
        check("R6 flag with reference selected", fail_flag, 1);
        check("R6 no override on reference", sel_override, 0);
        check("R5 exception on reference", exc_cnt, 1);
        src_is_ref = 1'b0;

        // R4: primary far too slow (300 reference cycles per period)
        run_prim(3000, 300);
        do_reset();
        wait_cyc(1200);
        check("R4 too slow clock flagged", fail_flag, 1);
        check("R5 single exception for slow clock", exc_cnt, 1);

        // R8: detection disabled, then enabled
        run_prim(3, 1);
        set_en(1'b0);
        do_reset();
        wait_cyc(50);
        prim_run = 1'b0;
        wait_cyc(1000);
        check("R8 disabled no flag", fail_flag, 0);
        check("R8 disabled no override", sel_override, 0);
        set_en(1'b1);
        wait_cyc(WIN - 20);
        check("R8 window restarted at enable", fail_flag, 0);
        wait_cyc(40);
        check("R8 flagged after enable", fail_flag, 1);

        // R9: reference monitor failure blinds detection until reset
        run_prim(3, 1);
        set_en(1'b1);
        do_reset();
        wait_cyc(50);
        refmon_fail = 1'b1;
        blind_m     = 1'b1;
        wait_cyc(1);
        refmon_fail = 1'b0;
        prim_run    = 1'b0;
        wait_cyc(600);
        set_en(1'b0);
        wait_cyc(5);
        set_en(1'b1);
        wait_cyc(600);
        check("R9 blinded no flag", fail_flag, 0);
        check("R9 blinded no exception", exc_cnt, 0);
        run_prim(3, 1);
        do_reset();
        wait_cyc(50);
        prim_run = 1'b0;
        wait_cyc(WIN + 10);
        check("R9 detection back after reset", fail_flag, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule